// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a read or write burst on a synchronous DRAM style memory. A start pulse captures a start column, a three-bit length code and an ordering bit. Each later advance pulse moves the column output on by one beat. Fixed bursts of 2, 4 or 8 beats stay inside their aligned block of columns. In sequential order they count upward and wrap. In interleaved order the low bits are the beat number XORed with the low bits of the start column.

A length code with its top bit set selects a full-row burst. That burst increments the entire column field, wraps from the last column to column zero, and runs until it is cut off by the terminate input. A last-beat flag marks the final beat of a fixed burst, and the advance that follows that beat ends the burst.

The block sits beside the command logic of a memory controller. That logic owns the data path, the bank state and the read latency. This block only supplies column numbers.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, busy_o and last_o are 0 and col_o is 0.
- R2: A start pulse sets busy_o one cycle later, and col_o then shows the captured start column as beat 0, whatever the state was before.
- R3: Length codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 beats; any code with bit 2 set selects a full-row burst.
- R4: With ordering bit 0 in a fixed burst, each advance sets the in-block bits to the previous column plus one, wrapping inside the block.
- R5: With ordering bit 1 in a fixed burst, beat k shows the in-block bits equal to k XOR the start column's in-block bits.
- R6: In a fixed burst of 2^n beats, only column bits below n ever change; all higher bits keep their start value.
- R7: In a full-row burst, each advance adds one to the whole column field, wrapping from all ones to zero, and the ordering bit has no effect.
- R8: last_o is 1 exactly while a fixed burst is on its final beat (beat index = length - 1); it is never 1 in a full-row burst or while idle.
- R9: An advance taken while last_o is 1 clears busy_o on the next cycle and leaves col_o unchanged.
- R10: term_i clears busy_o on the next cycle in every mode and leaves col_o unchanged; a start in the same cycle takes priority over term_i.
- R11: While busy_o is 0, advance pulses are ignored and col_o holds its value.
- R12: A 1-beat burst raises last_o on its first beat, and its column never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst and capture the settings |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code (000=1, 001=2, 010=4, 011=8, 1xx=full row) |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| step_i | input | 1 | Advance to the next beat |
| term_i | input | 1 | Stop the current burst |
| col_o | output | COL_W | Column address of the current beat |
| busy_o | output | 1 | A burst is in progress |
| last_o | output | 1 | Current beat is the last of a fixed burst |

## Verification
The bound checker watches the following on every cycle:
- the start column loading;
- termination, and the end of a burst after its last beat;
- col_o holding while idle;
- the bits above the 8-beat block staying fixed during any fixed burst;
- last_o never appearing while idle.

The exact beat order cannot be seen from one cycle, because it depends on the captured start column and on the beat count. This covers sequential wrap, interleaved XOR order, full-row wrap past the last column, and the beat count of each length code. Only the bench's reference model can show these, over randomized and directed bursts.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   // Number of column bits an interleaved burst may touch (8-beat block).
   localparam int ILV_BITS = 3;

   typedef struct packed {
      logic [2:0] len_code;
      logic       ilv;
   } bcs_cfg_t;

   // A code with its top bit set means a full-row burst.
   function automatic logic is_fixed(input logic [2:0] code);
      return !code[2];
   endfunction
endpackage

// File: rtl/bcs_mask.sv
module bcs_mask #(
   parameter int COL_W = 8
) (
   input  logic [2:0]       code_i,
   output logic [COL_W-1:0] mask_o,
   output logic             fixed_o
);
   assign fixed_o = bcs_pkg::is_fixed(code_i);

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < bcs_pkg::ILV_BITS) begin : g_low
         assign mask_o[i] = code_i[2] | (int'(code_i[1:0]) > i);
      end else begin : g_high
         assign mask_o[i] = code_i[2];
      end
   end
endmodule

// File: rtl/bcs_next.sv
module bcs_next #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] cur_i,
   input  logic [2:0]       base_lo_i,
   input  logic [2:0]       beat_lo_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   input  logic             fixed_i,
   output logic [COL_W-1:0] nxt_o
);
   logic [COL_W-1:0] inc;
   logic [2:0]       ilv_lo;
   logic [COL_W-1:0] cand;

   assign inc    = cur_i + 1'b1;
   assign ilv_lo = (beat_lo_i + 3'd1) ^ base_lo_i;

   always_comb begin
      if (fixed_i && ilv_i) cand = {cur_i[COL_W-1:3], ilv_lo};
      else                  cand = inc;
   end

   assign nxt_o = (cur_i & ~mask_i) | (cand & mask_i);
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             term_i,
   input  logic             step_i,
   input  logic             last_i,
   output logic             busy_o,
   output logic             adv_o,
   output logic [COL_W-1:0] beat_o
);
   logic             busy_q;
   logic [COL_W-1:0] beat_q;

   assign adv_o  = busy_q & step_i & !start_i & !term_i & !last_i;
   assign busy_o = busy_q;
   assign beat_o = beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         beat_q <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         beat_q <= '0;
      end else if (term_i) begin
         busy_q <= 1'b0;
      end else if (busy_q && step_i) begin
         if (last_i) busy_q <= 1'b0;
         else        beat_q <= beat_q + 1'b1;
      end
   end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_code_i,
   input  logic             ilv_i,
   input  logic             step_i,
   input  logic             term_i,
   output logic [COL_W-1:0] col_o,
   output logic             busy_o,
   output logic             last_o
);
   import bcs_pkg::*;

   if (COL_W < ILV_BITS) begin : g_bad_width
      $error("burst_col_seq: COL_W must be at least 3");
   end

   bcs_cfg_t         cfg_q;
   logic [2:0]       base_lo_q;
   logic [COL_W-1:0] col_q;
   logic [COL_W-1:0] mask;
   logic             fixed;
   logic [COL_W-1:0] nxt;
   logic [COL_W-1:0] beat;
   logic             adv;
   logic             busy;
   logic             last;

   bcs_mask #(.COL_W(COL_W)) u_mask (
      .code_i (cfg_q.len_code),
      .mask_o (mask),
      .fixed_o(fixed)
   );

   bcs_next #(.COL_W(COL_W)) u_next (
      .cur_i    (col_q),
      .base_lo_i(base_lo_q),
      .beat_lo_i(beat[2:0]),
      .mask_i   (mask),
      .ilv_i    (cfg_q.ilv),
      .fixed_i  (fixed),
      .nxt_o    (nxt)
   );

   assign last = busy & fixed & (beat == mask);

   bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .term_i (term_i),
      .step_i (step_i),
      .last_i (last),
      .busy_o (busy),
      .adv_o  (adv),
      .beat_o (beat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         base_lo_q <= '0;
         col_q     <= '0;
      end else if (start_i) begin
         cfg_q.len_code <= len_code_i;
         cfg_q.ilv      <= ilv_i;
         base_lo_q      <= start_col_i[2:0];
         col_q          <= start_col_i;
      end else if (adv) begin
         col_q <= nxt;
      end
   end

   assign col_o  = col_q;
   assign busy_o = busy;
   assign last_o = last;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic             fixed_req_i,
   input logic             step_i,
   input logic             term_i,
   input logic [COL_W-1:0] col_o,
   input logic             busy_o,
   input logic             last_o
);
   logic fixed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fixed_q <= 1'b0;
      else if (start_i) fixed_q <= fixed_req_i;
   end

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o && col_o == $past(start_col_i));

   assert_idle_no_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !last_o);

   assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && step_i && !start_i |=> !busy_o && $stable(col_o));

   assert_term_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      term_i && !start_i |=> !busy_o && $stable(col_o));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> $stable(col_o));

   assert_block_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && fixed_q && !start_i |=> $stable(col_o[COL_W-1:3]));
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .start_col_i(start_col_i),
   .fixed_req_i(!len_code_i[2]),
   .step_i     (step_i),
   .term_i     (term_i),
   .col_o      (col_o),
   .busy_o     (busy_o),
   .last_o     (last_o)
);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] start_col_i = '0;
   logic [2:0]   len_code_i = '0;
   logic         ilv_i = 1'b0;
   logic         step_i = 1'b0;
   logic         term_i = 1'b0;
   logic [W-1:0] col_o;
   logic         busy_o;
   logic         last_o;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   burst_col_seq #(.COL_W(W)) u0 (.*);

   function automatic logic [W-1:0] exp_col(logic [W-1:0] s, logic [2:0] code,
                                            bit ilv, int k);
      logic [W-1:0] m, lo;
      if (code[2]) return s + W'(k);
      m  = W'((1 << code[1:0]) - 1);
      lo = ilv ? (W'(k) ^ s) : (s + W'(k));
      return (s & ~m) | (lo & m);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pulse(bit st, bit sp, bit tm);
      @(negedge clk);
      start_i = st; step_i = sp; term_i = tm;
      @(negedge clk);
      start_i = 1'b0; step_i = 1'b0; term_i = 1'b0;
   endtask

   task automatic do_start(logic [W-1:0] s, logic [2:0] code, bit ilv);
      @(negedge clk);
      start_col_i = s; len_code_i = code; ilv_i = ilv; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      start_col_i = W'($urandom); len_code_i = 3'($urandom); ilv_i = 1'($urandom);
      chk("R2", "busy after start", int'(busy_o), 1);
      chk("R2", "col after start", int'(col_o), int'(s));
   endtask

   task automatic run_burst(logic [W-1:0] s, logic [2:0] code, bit ilv,
                            int full_steps, int term_at);
      int len;
      logic [W-1:0] m, e;
      string rq;
      len = code[2] ? full_steps : (1 << code[1:0]);
      m   = code[2] ? '1 : W'((1 << code[1:0]) - 1);
      rq  = code[2] ? "R7" : (ilv ? "R5" : "R4");
      do_start(s, code, ilv);
      for (int k = 0; k < len; k++) begin
         e = exp_col(s, code, ilv, k);
         chk(rq, "beat column", int'(col_o), int'(e));
         chk("R8", "last flag", int'(last_o), int'(!code[2] && k == len - 1));
         if (!code[2]) chk("R6", "bits outside block", int'(col_o & ~m), int'(s & ~m));
         if (k == term_at) begin
            pulse(1'b0, 1'b0, 1'b1);
            chk("R10", "busy after term", int'(busy_o), 0);
            chk("R10", "col after term", int'(col_o), int'(e));
            return;
         end
         for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
            @(negedge clk);
            chk(rq, "hold without step", int'(col_o), int'(e));
         end
         pulse(1'b0, 1'b1, 1'b0);
         if (!code[2] && k == len - 1) begin
            chk("R9", "busy after last step", int'(busy_o), 0);
            chk("R9", "col after last step", int'(col_o), int'(e));
            chk("R3", "beats in burst", k + 1, 1 << code[1:0]);
         end
      end
      if (code[2]) begin
         e = exp_col(s, code, ilv, len);
         chk("R7", "full row still running", int'(busy_o), 1);
         chk("R7", "full row column", int'(col_o), int'(e));
         pulse(1'b0, 1'b0, 1'b1);
         chk("R10", "busy after term", int'(busy_o), 0);
         chk("R10", "col after term", int'(col_o), int'(e));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", int'(busy_o), 0);
      chk("R1", "last in reset", int'(last_o), 0);
      chk("R1", "col in reset", int'(col_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "col after reset", int'(col_o), 0);

      // R11: advance while idle is ignored
      pulse(1'b0, 1'b1, 1'b0);
      chk("R11", "idle step col", int'(col_o), 0);
      chk("R11", "idle step busy", int'(busy_o), 0);

      // R12: single-beat burst
      do_start(8'h5A, 3'b000, 1'b1);
      chk("R12", "last on first beat", int'(last_o), 1);
      pulse(1'b0, 1'b1, 1'b0);
      chk("R12", "col unchanged", int'(col_o), 8'h5A);
      chk("R12", "busy cleared", int'(busy_o), 0);

      // Directed orders: sequential wrap in a 4-block, interleaved 8, full-row wrap
      run_burst(8'h0E, 3'b010, 1'b0, 0, -1);
      run_burst(8'h35, 3'b011, 1'b1, 0, -1);
      run_burst(8'hFD, 3'b100, 1'b1, 5, -1);
      run_burst(8'h81, 3'b001, 1'b1, 0, -1);

      // R10: start wins over term in the same cycle
      @(negedge clk);
      start_col_i = 8'h44; len_code_i = 3'b011; ilv_i = 1'b0;
      start_i = 1'b1; term_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; term_i = 1'b0;
      chk("R10", "start over term busy", int'(busy_o), 1);
      chk("R10", "start over term col", int'(col_o), 8'h44);
      pulse(1'b0, 1'b0, 1'b1);
      chk("R10", "term clears", int'(busy_o), 0);

      for (int n = 0; n < 300; n++) begin
         logic [2:0] code;
         int ta;
         code = 3'($urandom);
         ta = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 7)) : -1;
         run_burst(W'($urandom), code, 1'($urandom), int'($urandom_range(1, 40)), ta);
         pulse(1'b0, 1'b1, 1'b0);
         chk("R11", "idle after burst", int'(busy_o), 0);
      end

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule